// File: doc/BRIEF.md
# Masked Multidrop Address Filter

This block sits behind the receiver of a 9-bit multidrop serial link. For each finished frame it decides whether software should be told, and sets a receive flag if so. The frame is the received byte and a ninth bit. When the ninth bit is 1, the frame carries an address; when it is 0, the frame carries data. Two programmable registers give the node its identity: a slave address and an address-enable mask.

A frame matches the node's own address when every bit that the mask enables equals the slave address. Bits the mask leaves clear are don't-cares, so one node can answer a whole set of addresses. The node also has a broadcast address, formed as the bitwise OR of address and mask. A frame matches it when the frame has a 1 in every position where that OR has a 1.

Filtering is in force only when the filter enable is set and the receiver reports 9-bit mode. In every other case, each valid frame is passed on. The flag is registered on the clock edge that samples the frame strobe. The accepted byte is latched on the same edge. The flag stays set until software clears it through the write port.

Top module: `mdaf_filter`

## Requirements
- R1: After reset, `rx_flag` is 0, `rx_byte` is 0, and both the slave address and the mask hold zero.
- R2: When filtering is off (`filt_en`=0 or `mode_nine`=0), every frame sampled with `frame_valid`=1 sets `rx_flag` and loads `frame_byte` into `rx_byte` on that same clock edge, whatever `frame_bit9` is.
- R3: With filtering on, a frame whose `frame_bit9` is 0 leaves `rx_flag` and `rx_byte` unchanged.
- R4: With filtering on and `frame_bit9`=1, a frame is accepted when `(frame_byte ^ address) & mask` is all zeros (own-address match).
- R5: With filtering on and `frame_bit9`=1, a frame is accepted when `frame_byte` has a 1 in every bit where `address | mask` has a 1 (broadcast match).
- R6: With filtering on, an address frame that meets neither R4 nor R5 leaves `rx_flag` and `rx_byte` unchanged.
- R7: `rx_flag` holds its value until a write with `wr_sel`=2 clears it; the `wr_data` of that write is ignored. A write with `wr_sel`=3 has no effect.
- R8: An accepted frame that arrives while `rx_flag` is already set overwrites `rx_byte`. If an accepted frame and a clear write fall on the same edge, the flag ends up set.
- R9: A write with `wr_sel`=0 loads the slave address and a write with `wr_sel`=1 loads the mask. A frame sampled on any later edge uses the new value.
- R10: With the address and mask both zero and filtering on, every address frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | One-cycle strobe: a frame is complete |
| frame_byte | input | DATA_W | Received byte |
| frame_bit9 | input | 1 | Ninth bit; 1 marks an address frame |
| mode_nine | input | 1 | Receiver is in a 9-bit mode |
| filt_en | input | 1 | Enables address filtering |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 address, 1 mask, 2 clear flag, 3 none |
| wr_data | input | DATA_W | Write data |
| rx_flag | output | 1 | Receive flag |
| rx_byte | output | DATA_W | Latched copy of the last accepted byte |

## Verification
The hardest cases to reach from the ports are those where the own-address check and the broadcast check disagree. In these cases only one of the two comparisons decides whether the frame is accepted. The stimulus table reaches them by reprogramming the address and mask before each frame. It includes mask sets where the address differs only in masked-off bits, frames that fail the own-address check but hit the broadcast pattern, and frames that fail both.

Between vectors, a dedicated clear write drops the flag, so that every rejection shows at the flag port. The expected latched byte is carried forward in the bench, so that a rejection that disturbs the byte is also caught. Directed tests then put a clear write and an accepted frame on the same edge.

// File: rtl/mdaf_pkg.sv
package mdaf_pkg;
   // Write-port targets
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_MASK = 2'd1,
      SEL_CLR  = 2'd2,
      SEL_NONE = 2'd3
   } wsel_e;

   localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/mdaf_regs.sv
module mdaf_regs
   import mdaf_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] mask_q,
   output logic              clr_req
);
   wsel_e sel;
   assign sel = wsel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mask_q <= '0;
      end else if (wr_en) begin
         if (sel == SEL_ADDR) addr_q <= wr_data;
         if (sel == SEL_MASK) mask_q <= wr_data;
      end
   end

   assign clr_req = wr_en && (sel == SEL_CLR);

   AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> (addr_q == $past(wr_data))); // R9
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=> (mask_q == $past(wr_data))); // R9
   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_sel[1]) |=> ($stable(addr_q) && $stable(mask_q))); // R7
endmodule

// File: rtl/mdaf_match.sv
module mdaf_match #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          BCAST_EN = 1'b1
) (
   input  logic [DATA_W-1:0] frame_byte,
   input  logic [DATA_W-1:0] addr,
   input  logic [DATA_W-1:0] mask,
   output logic              given_hit,
   output logic              bcast_hit
);
   logic [DATA_W-1:0] g_ok;

   // Own-address compare: a bit passes when masked off or equal
   for (genvar i = 0; i < DATA_W; i++) begin : g_given
      assign g_ok[i] = ~mask[i] | ~(frame_byte[i] ^ addr[i]);
   end
   assign given_hit = &g_ok;

   if (BCAST_EN) begin : g_bcast
      logic [DATA_W-1:0] b_ok;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         // broadcast pattern bit set => frame bit must be 1
         assign b_ok[i] = ~(addr[i] | mask[i]) | frame_byte[i];
      end
      assign bcast_hit = &b_ok;
   end else begin : g_no_bcast
      assign bcast_hit = 1'b0;
   end

   always_comb begin
      if (mask == '0) begin
         AST_ZERO_MASK_ALL: assert (given_hit); // R10
      end
   end
endmodule

// File: rtl/mdaf_capture.sv
module mdaf_capture #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_valid,
   input  logic              accept,
   input  logic [DATA_W-1:0] frame_byte,
   input  logic              clr_req,
   output logic              flag_q,
   output logic [DATA_W-1:0] byte_q
);
   logic take;
   assign take = frame_valid && accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         byte_q <= '0;
      end else begin
         if (take)         flag_q <= 1'b1;
         else if (clr_req) flag_q <= 1'b0;
         if (take)         byte_q <= frame_byte;
      end
   end

   AST_TAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (flag_q && byte_q == $past(frame_byte))); // R8
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !take) |=> !flag_q); // R7
   AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !clr_req) |=> $stable(flag_q)); // R7
   AST_BYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(byte_q)); // R6
endmodule

// File: rtl/mdaf_filter.sv
module mdaf_filter
   import mdaf_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter bit          BCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_valid,
   input  logic [DATA_W-1:0] frame_byte,
   input  logic              frame_bit9,
   input  logic              mode_nine,
   input  logic              filt_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rx_flag,
   output logic [DATA_W-1:0] rx_byte
);
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $error("mdaf_filter: DATA_W out of range");
   end

   logic [DATA_W-1:0] addr_q, mask_q;
   logic clr_req, given_hit, bcast_hit, filt_on, accept;

   mdaf_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .addr_q(addr_q), .mask_q(mask_q), .clr_req(clr_req)
   );

   mdaf_match #(.DATA_W(DATA_W), .BCAST_EN(BCAST_EN)) u_match (
      .frame_byte(frame_byte), .addr(addr_q), .mask(mask_q),
      .given_hit(given_hit), .bcast_hit(bcast_hit)
   );

   assign filt_on = filt_en && mode_nine;
   assign accept  = !filt_on || (frame_bit9 && (given_hit || bcast_hit));

   mdaf_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .accept(accept),
      .frame_byte(frame_byte), .clr_req(clr_req),
      .flag_q(rx_flag), .byte_q(rx_byte)
   );

   AST_BYPASS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && !(filt_en && mode_nine)) |=> (rx_flag && rx_byte == $past(frame_byte))); // R2
   AST_DATA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && filt_en && mode_nine && !frame_bit9) |=> $stable(rx_byte)); // R3
   AST_DATA_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && filt_en && mode_nine && !frame_bit9 && !rx_flag) |=> !rx_flag); // R3
endmodule

// File: tb/tb_mdaf_filter.sv
module tb_mdaf_filter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_valid = 1'b0, frame_bit9 = 1'b0, mode_nine = 1'b0, filt_en = 1'b0;
   logic [7:0] frame_byte = '0, wr_data = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd3;
   logic       rx_flag;
   logic [7:0] rx_byte;

   int checks = 0, errors = 0;
   logic [7:0] exp_byte = '0;

   always #2 clk = ~clk;

   mdaf_filter dut (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_byte(frame_byte),
      .frame_bit9(frame_bit9), .mode_nine(mode_nine), .filt_en(filt_en),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rx_flag(rx_flag), .rx_byte(rx_byte)
   );

   // {addr, mask, en, mode, bit9, byte, accept, req}
   localparam int NV = 18;
   localparam logic [31:0] VEC [NV] = '{
      {8'hC0, 8'hFD, 1'b1, 1'b1, 1'b1, 8'hC2, 1'b1, 4'd4}, // R4
      {8'hC0, 8'hFE, 1'b1, 1'b1, 1'b1, 8'hC2, 1'b0, 4'd6}, // R6
      {8'hC0, 8'hFE, 1'b1, 1'b1, 1'b1, 8'hC1, 1'b1, 4'd4}, // R4
      {8'hC0, 8'hFD, 1'b1, 1'b1, 1'b1, 8'hC1, 1'b0, 4'd6}, // R6
      {8'hC0, 8'hF9, 1'b1, 1'b1, 1'b1, 8'hE6, 1'b0, 4'd6}, // R6
      {8'hE0, 8'hFA, 1'b1, 1'b1, 1'b1, 8'hE5, 1'b1, 4'd4}, // R4
      {8'hE0, 8'hFC, 1'b1, 1'b1, 1'b1, 8'hE3, 1'b1, 4'd4}, // R4
      {8'hE0, 8'hFC, 1'b1, 1'b1, 1'b1, 8'hE4, 1'b0, 4'd6}, // R6
      {8'hC0, 8'hFD, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 4'd5}, // R5
      {8'h30, 8'h0F, 1'b1, 1'b1, 1'b1, 8'h3F, 1'b1, 4'd5}, // R5
      {8'h30, 8'h0F, 1'b1, 1'b1, 1'b1, 8'hBF, 1'b1, 4'd5}, // R5
      {8'h30, 8'h0F, 1'b1, 1'b1, 1'b1, 8'h3E, 1'b0, 4'd6}, // R6
      {8'h30, 8'h0F, 1'b1, 1'b1, 1'b1, 8'hF0, 1'b1, 4'd4}, // R4
      {8'hC0, 8'hFD, 1'b1, 1'b1, 1'b0, 8'hC0, 1'b0, 4'd3}, // R3
      {8'hC0, 8'hFD, 1'b0, 1'b1, 1'b0, 8'h55, 1'b1, 4'd2}, // R2
      {8'hC0, 8'hFD, 1'b1, 1'b0, 1'b0, 8'h12, 1'b1, 4'd2}, // R2
      {8'hC0, 8'hFF, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 4'd2}, // R2
      {8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b1, 4'd10} // R10
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3;
   endtask

   // Drive one frame for one cycle; outputs checked at the following negedge
   task automatic frame(input logic b9, input logic [7:0] b);
      @(negedge clk);
      frame_valid = 1'b1; frame_bit9 = b9; frame_byte = b;
      @(negedge clk);
      frame_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 flag", {7'd0, rx_flag}, 8'd0);
      check("R1 byte", rx_byte, 8'd0);
      rst_n = 1'b1;
      filt_en = 1'b1; mode_nine = 1'b1;
      // R1/R10: cleared registers accept any address frame
      frame(1'b1, 8'hA7);
      exp_byte = 8'hA7;
      check("R10 flag", {7'd0, rx_flag}, 8'd1);
      check("R1 byte after zero regs", rx_byte, exp_byte);
      wr(2'd2, 8'h00);
      check("R7 clear", {7'd0, rx_flag}, 8'd0);
      // R3: data frame ignored while filtering with cleared registers
      frame(1'b0, 8'h11);
      check("R3 flag", {7'd0, rx_flag}, 8'd0);
      check("R3 byte", rx_byte, exp_byte);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         logic [31:0] v;
         v = VEC[i];
         wr(2'd0, v[31:24]);
         wr(2'd1, v[23:16]);
         wr(2'd2, 8'hFF);
         filt_en = v[15]; mode_nine = v[14];
         frame(v[13], v[12:5]);
         if (v[4]) exp_byte = v[12:5];
         check($sformatf("R%0d vec%0d flag", v[3:0], i), {7'd0, rx_flag}, {7'd0, v[4]});
         check($sformatf("R%0d vec%0d byte", v[3:0], i), rx_byte, exp_byte);
      end

      // R7: flag holds over idle cycles; select 3 does not clear
      filt_en = 1'b0;
      frame(1'b0, 8'h3C);
      exp_byte = 8'h3C;
      repeat (5) @(negedge clk);
      check("R7 hold", {7'd0, rx_flag}, 8'd1);
      wr(2'd3, 8'h00);
      check("R7 sel3 no clear", {7'd0, rx_flag}, 8'd1);
      // R8: overwrite while set
      frame(1'b0, 8'hC3);
      exp_byte = 8'hC3;
      check("R8 overwrite byte", rx_byte, exp_byte);
      check("R8 flag still set", {7'd0, rx_flag}, 8'd1);
      // R8: accepted frame and clear on the same edge -> set
      wr(2'd2, 8'h00);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd2; frame_valid = 1'b1; frame_bit9 = 1'b0; frame_byte = 8'h69;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd3; frame_valid = 1'b0;
      exp_byte = 8'h69;
      check("R8 same-edge flag", {7'd0, rx_flag}, 8'd1);
      check("R8 same-edge byte", rx_byte, exp_byte);

      // R9: new mask used by the very next frame
      wr(2'd2, 8'h00);
      filt_en = 1'b1; mode_nine = 1'b1;
      wr(2'd0, 8'h80);
      wr(2'd1, 8'hFF);
      frame(1'b1, 8'h81);
      check("R9 old mask rejects", {7'd0, rx_flag}, 8'd0);
      wr(2'd1, 8'hF0);
      frame(1'b1, 8'h81);
      exp_byte = 8'h81;
      check("R9 new mask accepts", {7'd0, rx_flag}, 8'd1);
      check("R9 byte", rx_byte, exp_byte);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule